// File: doc/BRIEF.md
# Virtually-Indexed Physically-Tagged Write-Through Data Cache

This block is a direct-mapped data cache for 32-bit word loads and stores. The CPU side hands over a base register value, a signed immediate, a write flag and an uncached flag. The block forms the effective address and starts the set lookup straight away, using virtual index bits. In the same cycle it sends the virtual page number to an external translator. The physical frame number comes back one cycle later. It is compared against the full stored tag of the line that the virtual index selected.

Stores write through to memory and never allocate a line. A load miss refills the whole line over a single-outstanding memory bus. Uncached (I/O-class) accesses skip the cache entirely and each one makes exactly one bus cycle, in program order.

The index reaches above the 4 KB page offset, and those upper index bits are the colour of an address. Two virtual aliases of one physical address with different colours can therefore sit in two lines at once. The block neither detects nor merges them. Keeping aliases the same colour is left to software.

The default build is 16 KB with 16-byte lines. That gives 1024 lines, index bits 13:4 and colour bits 13:12. Raising `CACHE_BYTES` to 64 KB moves the colour to bits 15:12, with up to 16 copies per physical word.

Top module: `vipt_dcache`

## Requirements
- R1: The effective address is `op_base` plus `op_imm` sign-extended from 16 bits. A request is taken in a cycle where `op_valid` and `op_ready` are both high. Each taken request produces exactly one single-cycle `done_valid` pulse.
- R2: While reset is held and after its release, `op_ready` is 1, `bus_req` is 0 and `done_valid` is 0.
- R3: A cached load miss makes four bus reads at byte offsets 0, 4, 8, 12 of the line, in that order. The line address is the frame number over effective-address bits 11:4. The block then installs the line and returns the word that effective-address bits 3:2 select.
- R4: A cached load that hits makes no bus cycle and returns the stored word.
- R5: A hit needs the valid bit set and the stored 20-bit frame number equal to the translated one. A different frame number at the same index misses and replaces the line.
- R6: Virtual aliases with different colour bits (13:12 by default) occupy separate lines. A store through one alias updates only that alias's line.
- R7: Every cached store makes one bus write of the data to the physical word address. A hit also updates the cached word. A miss allocates nothing.
- R8: An uncached access makes exactly one bus cycle (read or write), in request order. It never reads or changes cache contents.
- R9: `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` stay stable from when the request rises until the cycle `bus_ack` is seen.
- R10: A one-cycle `flush` pulse clears every valid bit. `op_ready` is low in the pulse cycle and for the 1024 cycles (one per line) that follow.
- R11: `xlat_req` is high exactly in the accept cycle, with `xlat_vpn` equal to effective-address bits 31:12. `xlat_pfn` is used in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| flush | input | 1 | one-cycle request to invalidate all lines |
| op_valid | input | 1 | CPU request present |
| op_ready | output | 1 | block can take a request |
| op_we | input | 1 | 1 = store, 0 = load |
| op_uncached | input | 1 | 1 = I/O-class access bypassing the cache |
| op_base | input | 32 | base register value |
| op_imm | input | 16 | signed immediate |
| op_wdata | input | 32 | store data |
| done_valid | output | 1 | one-cycle completion pulse |
| done_rdata | output | 32 | load result, valid with done_valid |
| xlat_req | output | 1 | translation request |
| xlat_vpn | output | 20 | virtual page number to translate |
| xlat_pfn | input | 20 | frame number, valid the cycle after xlat_req |
| bus_req | output | 1 | memory cycle request |
| bus_we | output | 1 | memory cycle is a write |
| bus_addr | output | 32 | physical word address |
| bus_wdata | output | 32 | write data |
| bus_ack | input | 1 | memory cycle complete |
| bus_rdata | input | 32 | read data, valid with bus_ack |

## Verification
The assertions assume the following about the inputs:
- The translator answers every `xlat_req` with a stable `xlat_pfn` in the following cycle.
- `bus_ack` is raised only while `bus_req` is high, for a single cycle per memory cycle.
- `flush` is a single-cycle pulse.

The bench's translator registers its answer on the request edge. Its memory model raises an acknowledge on the second sampling of a request and drops it on the next. The bench pulses `flush` only while the block is idle.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_BUS,
    ST_FILL,
    ST_FLUSH
  } cstate_e;
endpackage

// File: rtl/vipt_agen.sv
module vipt_agen #(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [IMM_W-1:0]  imm,
  output logic [ADDR_W-1:0] ea
);
  localparam int EXT_W = ADDR_W - IMM_W;

  logic [ADDR_W-1:0] imm_ext;

  generate
    if (EXT_W > 0) begin : g_ext
      assign imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
    end else begin : g_noext
      assign imm_ext = imm[ADDR_W-1:0];
    end
  endgenerate

  assign ea = base + imm_ext;
endmodule

// File: rtl/vipt_line_store.sv
module vipt_line_store #(
  parameter int LINES     = 1024,
  parameter int IDX_BITS  = 10,
  parameter int WPL       = 4,
  parameter int WSEL_BITS = 2,
  parameter int TAG_W     = 20
) (
  input  logic                     clk,
  input  logic                     rst_ni,
  input  logic [IDX_BITS-1:0]      idx,
  output logic                     rd_valid,
  output logic [TAG_W-1:0]         rd_tag,
  output logic [WPL-1:0][31:0]     rd_line,
  input  logic                     wr_en,
  input  logic [WSEL_BITS-1:0]     wr_wsel,
  input  logic [31:0]              wr_word,
  input  logic                     set_en,
  input  logic [TAG_W-1:0]         set_tag,
  input  logic                     clr_en,
  input  logic [IDX_BITS-1:0]      clr_idx
);
  logic [LINES-1:0]     valid_q, valid_n;
  logic [TAG_W-1:0]     tag_q  [LINES];
  logic [WPL-1:0][31:0] data_q [LINES];

  assign rd_valid = valid_q[idx];
  assign rd_tag   = tag_q[idx];
  assign rd_line  = data_q[idx];

  always_comb begin
    valid_n = valid_q;
    if (clr_en) valid_n[clr_idx] = 1'b0;
    if (set_en) valid_n[idx]     = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) valid_q <= '0;
    else         valid_q <= valid_n;
  end

  always_ff @(posedge clk) begin
    if (set_en) tag_q[idx] <= set_tag;
    if (wr_en)  data_q[idx][wr_wsel] <= wr_word;
  end

  // R10: a flush sweep never overlaps a line write or install
  a_r10_clear_exclusive: assert property (@(posedge clk) disable iff (!rst_ni)
    clr_en |-> !(set_en || wr_en));
endmodule

// File: rtl/vipt_ctrl.sv
module vipt_ctrl
  import vipt_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_BITS  = 12,
  parameter int OFF_BITS   = 4,
  parameter int IDX_BITS   = 10,
  parameter int WSEL_BITS  = 2,
  parameter int WPL        = 4,
  parameter int LINES      = 1024
) (
  input  logic                         clk,
  input  logic                         rst_ni,
  input  logic                         flush,
  input  logic                         op_valid,
  output logic                         op_ready,
  input  logic                         op_we,
  input  logic                         op_uncached,
  input  logic [ADDR_W-1:0]            ea,
  input  logic [31:0]                  op_wdata,
  output logic                         done_valid,
  output logic [31:0]                  done_rdata,
  output logic                         xlat_req,
  input  logic [ADDR_W-PAGE_BITS-1:0]  xlat_pfn,
  output logic [IDX_BITS-1:0]          idx,
  input  logic                         line_valid,
  input  logic [ADDR_W-PAGE_BITS-1:0]  line_tag,
  input  logic [WPL-1:0][31:0]         line_data,
  output logic                         wr_en,
  output logic [WSEL_BITS-1:0]         wr_wsel,
  output logic [31:0]                  wr_word,
  output logic                         set_en,
  output logic [ADDR_W-PAGE_BITS-1:0]  set_tag,
  output logic                         clr_en,
  output logic [IDX_BITS-1:0]          clr_idx,
  output logic                         bus_req,
  output logic                         bus_we,
  output logic [ADDR_W-1:0]            bus_addr,
  output logic [31:0]                  bus_wdata,
  input  logic                         bus_ack,
  input  logic [31:0]                  bus_rdata
);
  localparam int PFN_W = ADDR_W - PAGE_BITS;
  localparam logic [IDX_BITS-1:0]  LAST_IDX  = IDX_BITS'(LINES - 1);
  localparam logic [WSEL_BITS-1:0] LAST_BEAT = WSEL_BITS'(WPL - 1);

  cstate_e              state_q, state_n;
  logic [ADDR_W-1:0]    va_q, va_n;
  logic [PFN_W-1:0]     pfn_q, pfn_n;
  logic                 we_q, we_n, io_q, io_n;
  logic [31:0]          wdata_q, wdata_n, cap_q, cap_n;
  logic [WSEL_BITS-1:0] beat_q, beat_n;
  logic [IDX_BITS-1:0]  fcnt_q, fcnt_n;
  logic                 fpend_q, fpend_n;
  logic                 dv_q, dv_n;
  logic [31:0]          drd_q, drd_n;
  logic [WSEL_BITS-1:0] wsel_req;
  logic                 hit;

  assign wsel_req   = va_q[OFF_BITS-1:2];
  assign idx        = va_q[OFF_BITS +: IDX_BITS];
  assign clr_idx    = fcnt_q;
  assign set_tag    = pfn_q;
  assign bus_wdata  = wdata_q;
  assign done_valid = dv_q;
  assign done_rdata = drd_q;
  assign hit        = line_valid && (line_tag == xlat_pfn);

  always_comb begin
    state_n  = state_q;
    va_n     = va_q;
    pfn_n    = pfn_q;
    we_n     = we_q;
    io_n     = io_q;
    wdata_n  = wdata_q;
    cap_n    = cap_q;
    beat_n   = beat_q;
    fcnt_n   = fcnt_q;
    fpend_n  = fpend_q | flush;
    dv_n     = 1'b0;
    drd_n    = drd_q;
    op_ready = 1'b0;
    xlat_req = 1'b0;
    wr_en    = 1'b0;
    wr_wsel  = wsel_req;
    wr_word  = wdata_q;
    set_en   = 1'b0;
    clr_en   = 1'b0;
    bus_req  = 1'b0;
    bus_we   = 1'b0;
    bus_addr = {pfn_q, va_q[PAGE_BITS-1:OFF_BITS], beat_q, 2'b00};
    unique case (state_q)
      ST_IDLE: begin
        op_ready = !fpend_q && !flush;
        if (fpend_q || flush) begin
          state_n = ST_FLUSH;
          fcnt_n  = '0;
          fpend_n = 1'b0;
        end else if (op_valid) begin
          xlat_req = 1'b1;
          va_n     = ea;
          we_n     = op_we;
          io_n     = op_uncached;
          wdata_n  = op_wdata;
          state_n  = ST_LOOK;
        end
      end
      ST_LOOK: begin
        pfn_n = xlat_pfn;
        if (io_q) begin
          state_n = ST_BUS;
        end else if (!we_q) begin
          if (hit) begin
            dv_n    = 1'b1;
            drd_n   = line_data[wsel_req];
            state_n = ST_IDLE;
          end else begin
            beat_n  = '0;
            state_n = ST_FILL;
          end
        end else begin
          wr_en   = hit;
          state_n = ST_BUS;
        end
      end
      ST_BUS: begin
        bus_req  = 1'b1;
        bus_we   = we_q;
        bus_addr = {pfn_q, va_q[PAGE_BITS-1:2], 2'b00};
        if (bus_ack) begin
          dv_n    = 1'b1;
          if (!we_q) drd_n = bus_rdata;
          state_n = ST_IDLE;
        end
      end
      ST_FILL: begin
        bus_req = 1'b1;
        if (bus_ack) begin
          wr_en   = 1'b1;
          wr_wsel = beat_q;
          wr_word = bus_rdata;
          beat_n  = beat_q + 1'b1;
          if (beat_q == wsel_req) cap_n = bus_rdata;
          if (beat_q == LAST_BEAT) begin
            set_en  = 1'b1;
            dv_n    = 1'b1;
            drd_n   = (beat_q == wsel_req) ? bus_rdata : cap_q;
            state_n = ST_IDLE;
          end
        end
      end
      ST_FLUSH: begin
        clr_en = 1'b1;
        fcnt_n = fcnt_q + 1'b1;
        if (fcnt_q == LAST_IDX) state_n = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      va_q    <= '0;
      pfn_q   <= '0;
      we_q    <= 1'b0;
      io_q    <= 1'b0;
      wdata_q <= '0;
      cap_q   <= '0;
      beat_q  <= '0;
      fcnt_q  <= '0;
      fpend_q <= 1'b0;
      dv_q    <= 1'b0;
      drd_q   <= '0;
    end else begin
      state_q <= state_n;
      va_q    <= va_n;
      pfn_q   <= pfn_n;
      we_q    <= we_n;
      io_q    <= io_n;
      wdata_q <= wdata_n;
      cap_q   <= cap_n;
      beat_q  <= beat_n;
      fcnt_q  <= fcnt_n;
      fpend_q <= fpend_n;
      dv_q    <= dv_n;
      drd_q   <= drd_n;
    end
  end

  // R9: an unanswered bus request is held unchanged
  a_r9_bus_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)
                               && $stable(bus_wdata)));
  // R4: a cached load hit is followed by no memory cycle
  a_r4_hit_quiet: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_LOOK && !io_q && !we_q && line_valid && line_tag == xlat_pfn)
    |=> (!bus_req && done_valid));
  // R8: an uncached bus cycle never touches the line store
  a_r8_io_no_cache: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_req && io_q) |-> !(wr_en || set_en));
endmodule

// File: rtl/vipt_dcache.sv
module vipt_dcache #(
  parameter int ADDR_W      = 32,
  parameter int IMM_W       = 16,
  parameter int PAGE_BITS   = 12,
  parameter int CACHE_BYTES = 16384,
  parameter int LINE_BYTES  = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         op_valid,
  output logic                         op_ready,
  input  logic                         op_we,
  input  logic                         op_uncached,
  input  logic [ADDR_W-1:0]            op_base,
  input  logic [IMM_W-1:0]             op_imm,
  input  logic [31:0]                  op_wdata,
  output logic                         done_valid,
  output logic [31:0]                  done_rdata,
  output logic                         xlat_req,
  output logic [ADDR_W-PAGE_BITS-1:0]  xlat_vpn,
  input  logic [ADDR_W-PAGE_BITS-1:0]  xlat_pfn,
  output logic                         bus_req,
  output logic                         bus_we,
  output logic [ADDR_W-1:0]            bus_addr,
  output logic [31:0]                  bus_wdata,
  input  logic                         bus_ack,
  input  logic [31:0]                  bus_rdata
);
  localparam int OFF_BITS  = $clog2(LINE_BYTES);
  localparam int LINES     = CACHE_BYTES / LINE_BYTES;
  localparam int IDX_BITS  = $clog2(LINES);
  localparam int WPL       = LINE_BYTES / 4;
  localparam int WSEL_BITS = OFF_BITS - 2;
  localparam int PFN_W     = ADDR_W - PAGE_BITS;

  logic [1:0]           rst_sync_q;
  logic                 rst_ni;
  logic [ADDR_W-1:0]    ea;
  logic [IDX_BITS-1:0]  idx, clr_idx;
  logic                 line_valid, wr_en, set_en, clr_en;
  logic [PFN_W-1:0]     line_tag, set_tag;
  logic [WPL-1:0][31:0] line_data;
  logic [WSEL_BITS-1:0] wr_wsel;
  logic [31:0]          wr_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni   = rst_sync_q[1];
  assign xlat_vpn = ea[ADDR_W-1:PAGE_BITS];

  vipt_agen #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_agen (
    .base(op_base), .imm(op_imm), .ea(ea)
  );

  vipt_line_store #(
    .LINES(LINES), .IDX_BITS(IDX_BITS), .WPL(WPL),
    .WSEL_BITS(WSEL_BITS), .TAG_W(PFN_W)
  ) u_store (
    .clk(clk), .rst_ni(rst_ni), .idx(idx),
    .rd_valid(line_valid), .rd_tag(line_tag), .rd_line(line_data),
    .wr_en(wr_en), .wr_wsel(wr_wsel), .wr_word(wr_word),
    .set_en(set_en), .set_tag(set_tag),
    .clr_en(clr_en), .clr_idx(clr_idx)
  );

  vipt_ctrl #(
    .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .OFF_BITS(OFF_BITS),
    .IDX_BITS(IDX_BITS), .WSEL_BITS(WSEL_BITS), .WPL(WPL), .LINES(LINES)
  ) u_ctrl (
    .clk(clk), .rst_ni(rst_ni), .flush(flush),
    .op_valid(op_valid), .op_ready(op_ready), .op_we(op_we),
    .op_uncached(op_uncached), .ea(ea), .op_wdata(op_wdata),
    .done_valid(done_valid), .done_rdata(done_rdata),
    .xlat_req(xlat_req), .xlat_pfn(xlat_pfn),
    .idx(idx), .line_valid(line_valid), .line_tag(line_tag), .line_data(line_data),
    .wr_en(wr_en), .wr_wsel(wr_wsel), .wr_word(wr_word),
    .set_en(set_en), .set_tag(set_tag), .clr_en(clr_en), .clr_idx(clr_idx),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  // R10: no request is taken while lines are being invalidated
  a_r10_flush_blocks: assert property (@(posedge clk) disable iff (!rst_ni)
    clr_en |-> !op_ready);
  // R1: completion is a single-cycle pulse
  a_r1_done_pulse: assert property (@(posedge clk) disable iff (!rst_ni)
    done_valid |=> !done_valid);
  // R11: translation is asked only for a request being taken
  a_r11_xlat_on_accept: assert property (@(posedge clk) disable iff (!rst_ni)
    xlat_req |-> (op_valid && op_ready));
endmodule

// File: tb/tb_vipt_dcache.sv
module tb_vipt_dcache;
  localparam int LINES = 1024;

  logic clk = 1'b0;
  logic rst_n;
  logic flush, op_valid, op_ready, op_we, op_uncached;
  logic [31:0] op_base, op_wdata, done_rdata, bus_addr, bus_wdata, bus_rdata;
  logic [15:0] op_imm;
  logic done_valid, xlat_req, bus_req, bus_we, bus_ack;
  logic [19:0] xlat_vpn, xlat_pfn;

  int checks = 0, failures = 0;
  int bus_cnt = 0;
  logic        log_we   [64];
  logic [31:0] log_addr [64];
  logic [31:0] ov_addr  [32];
  logic [31:0] ov_data  [32];
  int          ov_n = 0;
  logic [19:0] last_vpn;
  int          bphase = 0;
  logic [31:0] b_addr_r;
  logic        b_we_r;

  always #5 clk = ~clk;

  vipt_dcache dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .op_valid(op_valid), .op_ready(op_ready),
    .op_we(op_we), .op_uncached(op_uncached), .op_base(op_base), .op_imm(op_imm),
    .op_wdata(op_wdata), .done_valid(done_valid), .done_rdata(done_rdata),
    .xlat_req(xlat_req), .xlat_vpn(xlat_vpn), .xlat_pfn(xlat_pfn),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  function automatic logic [19:0] map_vpn(input logic [19:0] v);
    case (v)
      20'h1, 20'h2: return 20'h0000F;
      20'h3:        return 20'h00010;
      20'h5:        return 20'h0001F;
      default:      return v + 20'h100;
    endcase
  endfunction

  function automatic logic [31:0] mem_val(input logic [31:0] a);
    logic [31:0] v = a ^ 32'h5A00_00C3;
    for (int i = 0; i < ov_n; i++) if (ov_addr[i] == a) v = ov_data[i];
    return v;
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // translator: answers on the request edge, valid the next cycle
  always @(posedge clk) if (xlat_req) begin
    xlat_pfn <= map_vpn(xlat_vpn);
    last_vpn <= xlat_vpn;
  end

  // memory model: acknowledge on the second sample of a request
  always @(negedge clk) begin
    case (bphase)
      0: begin
        bus_ack <= 1'b0;
        if (bus_req) begin
          b_addr_r = bus_addr; b_we_r = bus_we; bphase = 1;
        end
      end
      1: begin
        check(bus_req && bus_addr == b_addr_r && bus_we == b_we_r, "R9 held", bus_addr, b_addr_r);
        if (bus_cnt < 64) begin log_we[bus_cnt] = bus_we; log_addr[bus_cnt] = bus_addr; end
        bus_cnt++;
        bus_rdata <= mem_val(bus_addr);
        if (bus_we && ov_n < 32) begin ov_addr[ov_n] = bus_addr; ov_data[ov_n] = bus_wdata; ov_n++; end
        bus_ack <= 1'b1;
        bphase = 2;
      end
      default: begin bus_ack <= 1'b0; bphase = 0; end
    endcase
  end

  task automatic do_op(input logic we, input logic io, input logic [31:0] base,
                       input logic [15:0] imm, input logic [31:0] wd,
                       output logic [31:0] rd, output int nbus);
    int start;
    @(negedge clk);
    while (!op_ready) @(negedge clk);
    start = bus_cnt;
    op_valid = 1'b1; op_we = we; op_uncached = io; op_base = base; op_imm = imm; op_wdata = wd;
    @(negedge clk);
    op_valid = 1'b0;
    while (!done_valid) @(negedge clk);
    rd = done_rdata;
    nbus = bus_cnt - start;
  endtask

  task automatic t_reset();
    check(op_ready == 1'b1, "R2 ready", {31'b0, op_ready}, 1);
    check(bus_req == 1'b0, "R2 bus idle", {31'b0, bus_req}, 0);
    check(done_valid == 1'b0, "R2 no done", {31'b0, done_valid}, 0);
  endtask

  task automatic t_miss_then_hit();
    logic [31:0] rd; int nb, s;
    s = bus_cnt;
    do_op(0, 0, 32'h1000, 16'h0014, 0, rd, nb);
    check(last_vpn == 20'h1, "R11 vpn", {12'b0, last_vpn}, 1);
    check(nb == 4, "R3 fill beats", nb, 4);
    for (int i = 0; i < 4; i++)
      check(!log_we[s+i] && log_addr[s+i] == 32'hF010 + 4*i, "R3 fill order",
            log_addr[s+i], 32'hF010 + 4*i);
    check(rd == mem_val(32'hF014), "R3 fill word", rd, mem_val(32'hF014));
    do_op(0, 0, 32'h1020, 16'hFFF4, 0, rd, nb);
    check(nb == 0, "R4 hit no bus", nb, 0);
    check(rd == mem_val(32'hF014), "R1 R4 negative imm hit", rd, mem_val(32'hF014));
  endtask

  task automatic t_alias();
    logic [31:0] rd; int nb;
    do_op(0, 0, 32'h2000, 16'h0014, 0, rd, nb);
    check(nb == 4, "R6 alias other colour misses", nb, 4);
    do_op(0, 0, 32'h1000, 16'h0014, 0, rd, nb);
    check(nb == 0, "R6 first alias still resident", nb, 0);
  endtask

  task automatic t_store_hit();
    logic [31:0] rd; int nb, s;
    s = bus_cnt;
    do_op(1, 0, 32'h1000, 16'h0014, 32'hDEAD0001, rd, nb);
    check(nb == 1 && log_we[s] && log_addr[s] == 32'hF014, "R7 write-through", log_addr[s], 32'hF014);
    do_op(0, 0, 32'h1000, 16'h0014, 0, rd, nb);
    check(nb == 0 && rd == 32'hDEAD0001, "R7 hit updated", rd, 32'hDEAD0001);
    do_op(0, 0, 32'h2000, 16'h0014, 0, rd, nb);
    check(nb == 0 && rd == (32'hF014 ^ 32'h5A00_00C3), "R6 alias not merged", rd,
          32'hF014 ^ 32'h5A00_00C3);
  endtask

  task automatic t_tag_full();
    logic [31:0] rd; int nb;
    do_op(0, 0, 32'h5000, 16'h0014, 0, rd, nb);
    check(nb == 4 && rd == mem_val(32'h1F014), "R5 other frame misses", rd, mem_val(32'h1F014));
    do_op(0, 0, 32'h1000, 16'h0014, 0, rd, nb);
    check(nb == 4 && rd == 32'hDEAD0001, "R5 replaced line refetched", rd, 32'hDEAD0001);
  endtask

  task automatic t_store_miss();
    logic [31:0] rd; int nb, s;
    s = bus_cnt;
    do_op(1, 0, 32'h3000, 16'h0008, 32'h0000_1234, rd, nb);
    check(nb == 1 && log_we[s] && log_addr[s] == 32'h10008, "R7 miss write", log_addr[s], 32'h10008);
    do_op(0, 0, 32'h3000, 16'h0008, 0, rd, nb);
    check(nb == 4 && rd == 32'h1234, "R7 no allocate", nb, 4);
  endtask

  task automatic t_uncached();
    logic [31:0] rd; int nb, s;
    do_op(0, 1, 32'h1000, 16'h0018, 0, rd, nb);
    check(nb == 1 && rd == mem_val(32'hF018), "R8 io load bus", rd, mem_val(32'hF018));
    do_op(1, 1, 32'h1000, 16'h0018, 32'h0000BEEF, rd, nb);
    check(nb == 1, "R8 io store one cycle", nb, 1);
    do_op(0, 0, 32'h1000, 16'h0018, 0, rd, nb);
    check(nb == 0 && rd == (32'hF018 ^ 32'h5A00_00C3), "R8 cache untouched", rd,
          32'hF018 ^ 32'h5A00_00C3);
    s = bus_cnt;
    do_op(1, 1, 32'h1000, 16'h0000, 32'hA, rd, nb);
    do_op(0, 1, 32'h1000, 16'h0004, 0, rd, nb);
    do_op(1, 1, 32'h1000, 16'h0008, 32'hC, rd, nb);
    check(bus_cnt - s == 3, "R8 io count", bus_cnt - s, 3);
    check(log_we[s] && log_addr[s] == 32'hF000, "R8 order 0", log_addr[s], 32'hF000);
    check(!log_we[s+1] && log_addr[s+1] == 32'hF004, "R8 order 1", log_addr[s+1], 32'hF004);
    check(log_we[s+2] && log_addr[s+2] == 32'hF008, "R8 order 2", log_addr[s+2], 32'hF008);
  endtask

  task automatic t_flush();
    logic [31:0] rd; int nb, busy;
    @(negedge clk);
    flush = 1'b1;
    #1 busy = op_ready ? 0 : 1;
    @(negedge clk);
    flush = 1'b0;
    while (!op_ready && busy < LINES + 10) begin busy++; @(negedge clk); end
    check(busy == LINES + 1, "R10 flush span", busy, LINES + 1);
    do_op(0, 0, 32'h2000, 16'h0014, 0, rd, nb);
    check(nb == 4, "R10 line invalidated", nb, 4);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=%0d expected=0", checks);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; flush = 1'b0; op_valid = 1'b0; op_we = 1'b0; op_uncached = 1'b0;
    op_base = '0; op_imm = '0; op_wdata = '0; bus_ack = 1'b0; bus_rdata = '0;
    xlat_pfn = '0; last_vpn = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_miss_then_hit();
    t_alias();
    t_store_hit();
    t_tag_full();
    t_store_miss();
    t_uncached();
    t_flush();
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule